// File: doc/BRIEF.md
# Parallel-Translation Cache Lookup

This block is the load lookup path of a small first-level data cache whose set index lies wholly inside the page offset of the virtual address. In the cycle a load is accepted, a fully associative translation buffer matches the virtual page number while the cache arrays read every way of the indexed set. Neither lookup waits for the other. In the next cycle the translated physical page number is compared with the physical tag of each way. The result is registered and returned as a hit or miss with the selected data word.

The translation buffer and the line storage are loaded through two simple write ports. The buffer entry to load is named by its index. The cache way to load is picked by a per-set rotating pointer. The block has no table walker, no tuned replacement and no coherence; a miss is only reported.

Top module: `vipt_lookup`

## Requirements
- R1: The set index is taken from virtual address bits [11:6] and the 32-bit word within the 64-byte line from bits [5:2]. A hit returns that word of the matching line.
- R2: Each request receives exactly one response, with `resp_valid` high two cycles after the request cycle, whether it hits or misses. A new request may be made in every cycle.
- R3: When no valid translation entry holds the request's virtual page number (bits [31:12]), `resp_tlb_miss` is high, `resp_hit` is low and `resp_data` is zero.
- R4: A hit requires a valid way in the indexed set whose stored physical tag equals the translated page number. Two virtual pages that translate to the same physical page therefore hit the same line.
- R5: A translated request that matches no way returns `resp_hit` low, `resp_tlb_miss` low and `resp_data` zero.
- R6: A line refill writes the way given by that set's rotating pointer and marks it valid. After reset each pointer starts at way 0, then steps through ways 0 to 7 and wraps. Each refill of a set replaces the way that was filled longest ago in that set.
- R7: When two or more ways match, `resp_multi` is high together with `resp_hit`, and the data is the OR of the matching ways' words.
- R8: Synchronous active-low reset invalidates every translation entry and every cache line, returns all rotating pointers to way 0, and drives every response output to zero.
- R9: A translation write replaces the entry at `tlb_wr_idx`. The previous virtual page held there no longer translates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load request present this cycle |
| req_vaddr | input | 32 | Virtual byte address of the load |
| tlb_wr_en | input | 1 | Write one translation entry |
| tlb_wr_idx | input | 3 | Translation entry to write |
| tlb_wr_vpn | input | 20 | Virtual page number for the entry |
| tlb_wr_ppn | input | 20 | Physical page number for the entry |
| line_wr_en | input | 1 | Refill one cache line |
| line_wr_set | input | 6 | Set receiving the line |
| line_wr_ptag | input | 20 | Physical tag of the line |
| line_wr_data | input | 512 | Line contents, word 0 in the low bits |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | A way matched the translated tag |
| resp_tlb_miss | output | 1 | No translation was found |
| resp_multi | output | 1 | More than one way matched |
| resp_data | output | 32 | Selected data word, zero unless hit |

## Verification
The hardest states to reach are a set where two ways hold the same physical tag, and a set whose rotating pointer has wrapped so that a later refill evicts an earlier line. Neither can occur through ordinary use of a correct refill flow. The stimulus refills one set again with a tag it already holds, which produces the multi-match. It then pushes a long run of refills into another set, so that the oldest line is evicted and the lookups before and after the eviction show which way was replaced. Aliasing is reached by rewriting one translation entry so that a second virtual page maps to a physical page already in use.

// File: rtl/vipt_pkg.sv
// Shared definitions for the parallel-translation cache lookup.
// Assumes: 4 KB pages and 64-byte lines by default; every module takes
// its own widths as parameters, and the defaults here only seed them.
package vipt_pkg;
    localparam int DEF_VA_W     = 32;
    localparam int DEF_PAGE_W   = 12;
    localparam int DEF_LINE_W   = 6;
    localparam int DEF_PPN_W    = 20;
    localparam int DEF_WAYS     = 8;
    localparam int DEF_TLB_N    = 8;
    localparam int DEF_DATA_W   = 32;

    // Per-lookup outcome flags carried from the compare stage to the outputs.
    typedef struct packed {
        logic hit;
        logic xlat_miss;
        logic multi;
    } lookup_flags_t;
endpackage

// File: rtl/vipt_tlb.sv
// Fully associative translation buffer with a registered lookup result.
// Assumes: the lowest-index valid match wins if software loads duplicates.
// A write and a lookup in the same cycle return the value held before the write.
module vipt_tlb #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int TLB_N = 8,
    localparam int IW   = $clog2(TLB_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    output logic             hit_o,
    output logic [PPN_W-1:0] ppn_o
);
    logic [TLB_N-1:0] vld_q;
    logic [VPN_W-1:0] vpn_q [TLB_N];
    logic [PPN_W-1:0] ppn_q [TLB_N];
    logic             found;
    logic [PPN_W-1:0] sel_ppn;

    // Entry storage: valid bits reset, contents written by index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            vpn_q[wr_idx] <= wr_vpn;
            ppn_q[wr_idx] <= wr_ppn;
        end
    end

    // Parallel match of all entries, lowest index taking priority.
    always_comb begin
        found   = 1'b0;
        sel_ppn = '0;
        for (int i = TLB_N - 1; i >= 0; i--) begin
            if (vld_q[i] && vpn_q[i] == lk_vpn) begin
                found   = 1'b1;
                sel_ppn = ppn_q[i];
            end
        end
    end

    // Register the translation alongside the set read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_o <= 1'b0;
            ppn_o <= '0;
        end else begin
            hit_o <= found;
            ppn_o <= sel_ppn;
        end
    end

    // R9
    tlb_write_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/vipt_set_store.sv
// Tag, valid and line storage for all sets, with a rotating refill pointer per set.
// Assumes: WAYS is at least 2. A read returns all ways of one set one cycle
// after the index is presented. A refill and a read of the same set in the
// same cycle return the contents held before the refill.
module vipt_set_store #(
    parameter int SET_W  = 6,
    parameter int WAYS   = 8,
    parameter int PPN_W  = 20,
    parameter int LINE_W = 512,
    parameter int DATA_W = 32,
    localparam int SETS   = 1 << SET_W,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int WORD_W = $clog2(LINE_W / DATA_W)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            rd_set,
    input  logic [WORD_W-1:0]           rd_word,
    input  logic                        wr_en,
    input  logic [SET_W-1:0]            wr_set,
    input  logic [PPN_W-1:0]            wr_tag,
    input  logic [LINE_W-1:0]           wr_line,
    output logic [WAYS-1:0]             rd_vld_o,
    output logic [WAYS-1:0][PPN_W-1:0]  rd_tag_o,
    output logic [WAYS-1:0][DATA_W-1:0] rd_word_o
);
    logic [SETS-1:0][WAYS-1:0]  valid_q;
    logic [SETS-1:0][WAY_W-1:0] ptr_q;
    logic [PPN_W-1:0]           tag_q  [SETS][WAYS];
    logic [LINE_W-1:0]          line_q [SETS][WAYS];
    logic [WAY_W-1:0]           wr_way;

    assign wr_way = ptr_q[wr_set];

    // Valid bits and rotating pointers: cleared on reset, advanced on refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
            ptr_q[wr_set] <= (wr_way == WAY_W'(WAYS - 1)) ? '0 : wr_way + 1'b1;
        end
    end

    // Tag and line contents: written into the pointed way, never reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way]  <= wr_tag;
            line_q[wr_set][wr_way] <= wr_line;
        end
    end

    // Synchronous read of every way of the indexed set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld_o  <= '0;
            rd_tag_o  <= '0;
            rd_word_o <= '0;
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                rd_vld_o[w]  <= valid_q[rd_set][w];
                rd_tag_o[w]  <= tag_q[rd_set][w];
                rd_word_o[w] <= line_q[rd_set][w][int'(rd_word) * DATA_W +: DATA_W];
            end
        end
    end

    // R6
    refill_marks_way_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_set)][$past(wr_way)]);
    // R6
    refill_moves_pointer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ptr_q[$past(wr_set)] != $past(wr_way));
endmodule

// File: rtl/vipt_way_match.sv
// Physical tag compare across all ways of the read set, with word select.
// Assumes: its inputs are the registered set read and the registered
// translation of the same request; purely combinational.
module vipt_way_match #(
    parameter int WAYS   = 8,
    parameter int PPN_W  = 20,
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(WAYS) + 1
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][PPN_W-1:0]  tags,
    input  logic [WAYS-1:0][DATA_W-1:0] words,
    input  logic                        xlat_ok,
    input  logic [PPN_W-1:0]            ppn,
    output vipt_pkg::lookup_flags_t     flags,
    output logic [DATA_W-1:0]           word
);
    logic [WAYS-1:0] match;
    logic [CNT_W-1:0] cnt;

    // Compare each way, count matches and OR the matching words.
    always_comb begin
        cnt  = '0;
        word = '0;
        for (int w = 0; w < WAYS; w++) begin
            match[w] = vld[w] && xlat_ok && (tags[w] == ppn);
            if (match[w]) begin
                cnt  = cnt + 1'b1;
                word = word | words[w];
            end
        end
        flags.hit       = |match;
        flags.multi     = (cnt > CNT_W'(1));
        flags.xlat_miss = !xlat_ok;
    end
endmodule

// File: rtl/vipt_lookup.sv
// Lookup path of a virtually indexed, physically tagged data cache.
// Cycle of request: translation match and set read start together.
// Next cycle: physical tag compare; the response registers at its end.
// Assumes: refills are not aimed at a set being read in the same cycle.
module vipt_lookup #(
    parameter int VA_W     = vipt_pkg::DEF_VA_W,
    parameter int PAGE_W   = vipt_pkg::DEF_PAGE_W,
    parameter int LOFF_W   = vipt_pkg::DEF_LINE_W,
    parameter int PPN_W    = vipt_pkg::DEF_PPN_W,
    parameter int WAYS     = vipt_pkg::DEF_WAYS,
    parameter int TLB_N    = vipt_pkg::DEF_TLB_N,
    parameter int DATA_W   = vipt_pkg::DEF_DATA_W,
    localparam int SET_W   = PAGE_W - LOFF_W,
    localparam int VPN_W   = VA_W - PAGE_W,
    localparam int LINE_W  = 8 << LOFF_W,
    localparam int BYTE_W  = $clog2(DATA_W / 8),
    localparam int WORD_W  = LOFF_W - BYTE_W,
    localparam int TIDX_W  = $clog2(TLB_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              tlb_wr_en,
    input  logic [TIDX_W-1:0] tlb_wr_idx,
    input  logic [VPN_W-1:0]  tlb_wr_vpn,
    input  logic [PPN_W-1:0]  tlb_wr_ppn,
    input  logic              line_wr_en,
    input  logic [SET_W-1:0]  line_wr_set,
    input  logic [PPN_W-1:0]  line_wr_ptag,
    input  logic [LINE_W-1:0] line_wr_data,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_tlb_miss,
    output logic              resp_multi,
    output logic [DATA_W-1:0] resp_data
);
    logic                        s1_v;
    logic                        xlat_ok;
    logic [PPN_W-1:0]            xlat_ppn;
    logic [WAYS-1:0]             rd_vld;
    logic [WAYS-1:0][PPN_W-1:0]  rd_tag;
    logic [WAYS-1:0][DATA_W-1:0] rd_word;
    vipt_pkg::lookup_flags_t     flags;
    logic [DATA_W-1:0]           sel_word;

    vipt_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .TLB_N(TLB_N)) tlb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_vpn (req_vaddr[VA_W-1:PAGE_W]),
        .wr_en  (tlb_wr_en),
        .wr_idx (tlb_wr_idx),
        .wr_vpn (tlb_wr_vpn),
        .wr_ppn (tlb_wr_ppn),
        .hit_o  (xlat_ok),
        .ppn_o  (xlat_ppn)
    );

    vipt_set_store #(.SET_W(SET_W), .WAYS(WAYS), .PPN_W(PPN_W),
                     .LINE_W(LINE_W), .DATA_W(DATA_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (req_vaddr[PAGE_W-1:LOFF_W]),
        .rd_word   (req_vaddr[LOFF_W-1:BYTE_W]),
        .wr_en     (line_wr_en),
        .wr_set    (line_wr_set),
        .wr_tag    (line_wr_ptag),
        .wr_line   (line_wr_data),
        .rd_vld_o  (rd_vld),
        .rd_tag_o  (rd_tag),
        .rd_word_o (rd_word)
    );

    vipt_way_match #(.WAYS(WAYS), .PPN_W(PPN_W), .DATA_W(DATA_W)) match_i (
        .vld     (rd_vld),
        .tags    (rd_tag),
        .words   (rd_word),
        .xlat_ok (xlat_ok),
        .ppn     (xlat_ppn),
        .flags   (flags),
        .word    (sel_word)
    );

    // Request-valid stage aligned with the registered translation and set read.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_v <= 1'b0;
        else        s1_v <= req_valid;
    end

    // Response registers: fixed latency, data forced to zero unless hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid    <= 1'b0;
            resp_hit      <= 1'b0;
            resp_tlb_miss <= 1'b0;
            resp_multi    <= 1'b0;
            resp_data     <= '0;
        end else begin
            resp_valid    <= s1_v;
            resp_hit      <= s1_v && flags.hit;
            resp_tlb_miss <= s1_v && flags.xlat_miss;
            resp_multi    <= s1_v && flags.multi;
            resp_data     <= (s1_v && flags.hit) ? sel_word : '0;
        end
    end

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ##2 resp_valid);
    // R3
    tlb_miss_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_tlb_miss |-> !resp_hit);
    // R5
    miss_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_data == '0));
    // R7
    multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_multi |-> resp_hit);
endmodule

// File: tb/vipt_lookup_tb_top.sv
module vipt_lookup_tb_top;
    localparam int NSETS = 64;
    localparam int NWAYS = 8;
    localparam int NTLB  = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_vaddr = '0;
    logic         tlb_wr_en = 1'b0;
    logic [2:0]   tlb_wr_idx = '0;
    logic [19:0]  tlb_wr_vpn = '0;
    logic [19:0]  tlb_wr_ppn = '0;
    logic         line_wr_en = 1'b0;
    logic [5:0]   line_wr_set = '0;
    logic [19:0]  line_wr_ptag = '0;
    logic [511:0] line_wr_data = '0;
    logic         resp_valid, resp_hit, resp_tlb_miss, resp_multi;
    logic [31:0]  resp_data;

    vipt_lookup dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .tlb_wr_en(tlb_wr_en), .tlb_wr_idx(tlb_wr_idx), .tlb_wr_vpn(tlb_wr_vpn),
        .tlb_wr_ppn(tlb_wr_ppn), .line_wr_en(line_wr_en), .line_wr_set(line_wr_set),
        .line_wr_ptag(line_wr_ptag), .line_wr_data(line_wr_data),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_tlb_miss(resp_tlb_miss),
        .resp_multi(resp_multi), .resp_data(resp_data)
    );

    always #4 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    // Requirement model
    logic        m_tv  [NTLB];
    logic [19:0] m_vpn [NTLB];
    logic [19:0] m_ppn [NTLB];
    logic        m_lv  [NSETS][NWAYS];
    logic [19:0] m_tag [NSETS][NWAYS];
    int          m_ptr [NSETS];
    logic [19:0] base_vpn [NTLB];
    logic [19:0] base_ppn [NTLB];

    typedef struct {
        logic        v;
        logic [35:0] e;
        string       r;
    } slot_t;
    slot_t s0, s1;

    function automatic logic [31:0] gen_word(logic [19:0] t, int s, int w);
        return {t[11:0], 6'(s), 4'(w), 10'h2A5};
    endfunction

    task automatic chk(string r, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    function automatic logic [35:0] model_resp(logic [31:0] va);
        logic [19:0] ppn;
        logic        found;
        int          cnt;
        logic [31:0] d;
        int          set;
        int          w;
        found = 1'b0;
        ppn   = '0;
        for (int i = NTLB - 1; i >= 0; i--)
            if (m_tv[i] && m_vpn[i] == va[31:12]) begin found = 1'b1; ppn = m_ppn[i]; end
        if (!found) return {4'b1010, 32'h0};
        set = int'(va[11:6]);
        w   = int'(va[5:2]);
        cnt = 0;
        d   = '0;
        for (int k = 0; k < NWAYS; k++)
            if (m_lv[set][k] && m_tag[set][k] == ppn) begin
                cnt++;
                d = d | gen_word(ppn, set, w);
            end
        return {1'b1, cnt > 0, 1'b0, cnt > 1, d};
    endfunction

    // Advance one cycle: check the response due now, shift, clear drives.
    task automatic advance();
        @(negedge clk);
        if (s1.v) chk(s1.r, {resp_valid, resp_hit, resp_tlb_miss, resp_multi, resp_data}, s1.e);
        else      chk("R2 idle", {35'h0, resp_valid}, 36'h0);
        s1 = s0;
        s0.v = 1'b0; s0.e = '0; s0.r = "";
        req_valid = 1'b0; tlb_wr_en = 1'b0; line_wr_en = 1'b0;
    endtask

    task automatic lookup(logic [31:0] va, string r);
        advance();
        s0.v = 1'b1; s0.e = model_resp(va); s0.r = r;
        req_valid = 1'b1; req_vaddr = va;
    endtask

    task automatic idle();
        advance();
    endtask

    task automatic load_tlb(int idx, logic [19:0] vpn, logic [19:0] ppn);
        advance();
        tlb_wr_en = 1'b1; tlb_wr_idx = 3'(idx); tlb_wr_vpn = vpn; tlb_wr_ppn = ppn;
        m_tv[idx] = 1'b1; m_vpn[idx] = vpn; m_ppn[idx] = ppn;
    endtask

    task automatic refill(int set, logic [19:0] ptag);
        advance();
        line_wr_en = 1'b1; line_wr_set = 6'(set); line_wr_ptag = ptag;
        for (int w = 0; w < 16; w++) line_wr_data[w*32 +: 32] = gen_word(ptag, set, w);
        m_lv[set][m_ptr[set]] = 1'b1;
        m_tag[set][m_ptr[set]] = ptag;
        m_ptr[set] = (m_ptr[set] + 1) % NWAYS;
    endtask

    task automatic model_clear();
        for (int i = 0; i < NTLB; i++) m_tv[i] = 1'b0;
        for (int s = 0; s < NSETS; s++) begin
            m_ptr[s] = 0;
            for (int k = 0; k < NWAYS; k++) m_lv[s][k] = 1'b0;
        end
        s0.v = 1'b0; s1.v = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; tlb_wr_en = 1'b0; line_wr_en = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        chk("R8 outputs in reset", {resp_valid, resp_hit, resp_tlb_miss, resp_multi, resp_data}, 36'h0);
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] va_of(logic [19:0] vpn, int set, int w);
        return {vpn, 6'(set), 4'(w), 2'b00};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        for (int i = 0; i < NTLB; i++) begin
            base_vpn[i] = 20'h00010 + 20'(i * 'h111);
            base_ppn[i] = 20'h00800 + 20'(i * 'h35);
        end
        apply_reset();

        // R8/R3: nothing translates straight after reset
        lookup(va_of(base_vpn[0], 0, 0), "R8 no translation after reset");
        lookup(32'hFFFF_FFFC, "R3 empty buffer");
        for (int i = 0; i < NTLB; i++) load_tlb(i, base_vpn[i], base_ppn[i]);
        lookup(va_of(base_vpn[3], 7, 2), "R5 translated, no lines");
        lookup(va_of(20'h77777, 7, 2), "R3 unmapped page");

        // R1: one line per set, then sweep every set and word
        for (int s = 0; s < NSETS; s++) refill(s, base_ppn[s % NTLB]);
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < 16; w++)
                lookup(va_of(base_vpn[s % NTLB], s, w), "R1 set/word sweep");
        // R4/R5: right set, other physical page
        for (int s = 0; s < NSETS; s++)
            lookup(va_of(base_vpn[(s + 1) % NTLB], s, s % 16), "R4 tag mismatch");

        // R9 overwrite and R4 aliasing to a page already in use
        load_tlb(7, 20'hABCDE, base_ppn[2]);
        lookup(va_of(base_vpn[7], 7, 1), "R9 replaced entry no longer translates");
        lookup(va_of(20'hABCDE, 2, 5), "R4 alias hits same physical line");
        lookup(va_of(base_vpn[2], 2, 5), "R4 original page still hits");
        lookup(va_of(20'hABCDE, 10, 9), "R4 alias on other set");

        // R6: fill set 5 until its pointer wraps
        for (int k = 0; k < 7; k++) refill(5, 20'hF0000 + 20'(k));
        lookup(va_of(base_vpn[5], 5, 3), "R6 original line before wrap");
        refill(5, 20'hF0007);
        lookup(va_of(base_vpn[5], 5, 3), "R6 oldest line replaced on wrap");
        refill(5, base_ppn[5]);
        lookup(va_of(base_vpn[5], 5, 3), "R6 refill into second way");
        lookup(va_of(base_vpn[5], 5, 15), "R6 refill last word");

        // R7: duplicate physical tag in set 9
        refill(9, base_ppn[1]);
        for (int w = 0; w < 16; w++) lookup(va_of(base_vpn[1], 9, w), "R7 two ways match");

        // R2: alternate hit and miss every cycle, then with gaps
        for (int k = 0; k < 32; k++)
            lookup(va_of(base_vpn[k % 2 == 0 ? 0 : 3], 8 * (k % 8), k % 16), "R2 back-to-back");
        for (int k = 0; k < 8; k++) begin
            lookup(va_of(base_vpn[k % 7], 24 + k, k), "R2 spaced");
            idle();
        end

        // R8: reset again clears translations, lines and pointers
        apply_reset();
        lookup(va_of(base_vpn[0], 0, 0), "R8 translation cleared");
        load_tlb(0, base_vpn[0], base_ppn[0]);
        lookup(va_of(base_vpn[0], 0, 0), "R8 lines cleared");
        refill(0, base_ppn[0]);
        lookup(va_of(base_vpn[0], 0, 4), "R8 refill after reset");
        refill(0, 20'h12345);
        refill(0, base_ppn[0]);
        lookup(va_of(base_vpn[0], 0, 4), "R6 pointer restarted at way 0");

        repeat (3) idle();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule